// File: doc/BRIEF.md
# Background CRC-32 Memory Scrub Monitor

This block walks a protected memory region one word per enabled clock, for as long as it runs, and folds every word into a 32-bit cyclic redundancy code. When the last word of the region has been folded in, the result is compared with a reference code supplied on an input port. A mismatch raises an error flag that stays up until software or other logic clears it. The scan then starts again at the first word with a fresh seed. The block only reads the memory, so it runs alongside normal operation without stalling it.

How long it takes to detect a corruption depends on the size of the region and on how often the scan enable is high: one full pass takes 2^ADDR_W enabled cycles. The flag is available in two forms. One is a status bit for on-chip logic. The other is a registered copy meant to drive a device pin. Neither shows which word or bit is wrong, and the block makes no attempt to repair the memory.

Top module: `crc_scrub_monitor`

## Requirements
- R1: After reset, memAddr is 0 and errFlag, errPin and passDone are all 0.
- R2: Each clock with scanEn high advances memAddr by one. After address 2^ADDR_W-1 it returns to 0.
- R3: While scanEn is low, memAddr and the running CRC hold their values and passDone stays 0. When the scan resumes, the pass result is the same as for an uninterrupted pass.
- R4: The code is the non-reflected CRC with polynomial 0x04C11DB7. It is seeded with 0xFFFFFFFF and has no final inversion. Words are taken in ascending address order, each word most significant bit first. A pass whose result equals refCrc leaves errFlag unchanged. A single flipped bit anywhere in the region gives a mismatch.
- R5: A mismatching pass sets errFlag at the same clock edge that raises passDone.
- R6: errFlag stays at 1 until clrErr is sampled high, even if later passes match. If an error is set and clrErr is high at the same edge, the set wins.
- R7: errPin equals the value errFlag had one clock earlier.
- R8: passDone is a one-cycle pulse, raised once for every 2^ADDR_W enabled cycles, in the cycle when memAddr has just returned to 0.
- R9: Each pass reseeds the CRC, so an unchanged memory keeps matching the same reference on every later pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous reset, active low |
| scanEn | input | 1 | Clock enable for the scan; each high cycle consumes one word |
| memAddr | output | ADDR_W | Word address presented to the memory read port |
| memRdData | input | DATA_W | Read data for memAddr, valid in the same cycle |
| refCrc | input | 32 | Reference code for a full pass |
| clrErr | input | 1 | Clears the sticky error flag |
| errFlag | output | 1 | Sticky error status for on-chip logic |
| errPin | output | 1 | Registered copy of errFlag for an external pin |
| passDone | output | 1 | One-cycle pulse at the end of every pass |

## Verification
The assertions check the cycle-level rules on every clock: the address steps and wraps, the address holds while scanEn is low, passDone is a single-cycle pulse that coincides with address zero, errFlag only rises together with passDone and stays high unless cleared, and errPin trails errFlag by one cycle. Whether the code value itself is correct can only be shown by the bench's scenarios. These cover a matching region over successive passes, a wrong reference, a single-bit memory corruption, a pause in the middle of a pass, and a clear that arrives at the same edge as a new error.

// File: rtl/crc_scrub_pkg.sv
package crc_scrub_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  // strobes from control to datapath
  typedef struct packed {
    logic fold;      // consume memRdData this cycle
    logic lastWord;  // the word being consumed closes the pass
  } scanStrobe_t;
endpackage

// File: rtl/crc_scan_ctrl.sv
module crc_scan_ctrl
  import crc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanEn,
  output logic [ADDR_W-1:0] memAddr,
  output scanStrobe_t       strobe,
  output logic              passDone
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic [ADDR_W-1:0] addrReg;
  logic              atLast;

  assign atLast          = (addrReg == LAST_ADDR);
  assign strobe.fold     = scanEn;
  assign strobe.lastWord = scanEn && atLast;
  assign memAddr         = addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      passDone <= 1'b0;
    end else begin
      passDone <= strobe.lastWord;
      if (scanEn) begin
        addrReg <= atLast ? '0 : addrReg + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crc_scan_dp.sv
module crc_scan_dp
  import crc_scrub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [CRC_W-1:0]  refCrc,
  input  logic              clrErr,
  output logic              errFlag,
  output logic              errPin
);
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcNext;
  logic             mismatch;

  // fold one word into the running code, most significant bit first
  function automatic logic [CRC_W-1:0] foldWord(input logic [CRC_W-1:0] cur,
                                                input logic [DATA_W-1:0] word);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = cur;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ word[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  assign crcNext  = foldWord(crcReg, memRdData);
  assign mismatch = strobe.fold && strobe.lastWord && (crcNext != refCrc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg  <= CRC_SEED;
      errFlag <= 1'b0;
      errPin  <= 1'b0;
    end else begin
      errPin <= errFlag;
      if (strobe.fold) begin
        crcReg <= strobe.lastWord ? CRC_SEED : crcNext;
      end
      if (mismatch) begin
        errFlag <= 1'b1;
      end else if (clrErr) begin
        errFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crc_scrub_monitor.sv
module crc_scrub_monitor
  import crc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [31:0]       refCrc,
  input  logic              clrErr,
  output logic              errFlag,
  output logic              errPin,
  output logic              passDone
);
  scanStrobe_t strobe;

  crc_scan_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .scanEn(scanEn),
    .memAddr(memAddr), .strobe(strobe), .passDone(passDone)
  );

  crc_scan_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .refCrc(refCrc), .clrErr(clrErr), .errFlag(errFlag), .errPin(errPin)
  );
endmodule

// File: rtl/crc_scrub_monitor_chk.sv
module crc_scrub_monitor_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              scanEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              clrErr,
  input logic              errFlag,
  input logic              errPin,
  input logic              passDone
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && memAddr != LAST_ADDR) |=> (memAddr == $past(memAddr) + 1'b1)); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && memAddr == LAST_ADDR) |=> (memAddr == '0 && passDone)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |=> ($stable(memAddr) && !passDone)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    passDone |=> !passDone); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> passDone); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrErr) |=> errFlag); // R6
  AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    errPin == $past(errFlag)); // R7
endmodule

bind crc_scrub_monitor crc_scrub_monitor_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .scanEn(scanEn), .memAddr(memAddr), .clrErr(clrErr),
  .errFlag(errFlag), .errPin(errPin), .passDone(passDone)
);

// File: tb/crc_scrub_monitor_tb_top.sv
module crc_scrub_monitor_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NWORDS = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              scanEn = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memRdData;
  logic [31:0]       refCrc = '0;
  logic              clrErr = 1'b0;
  logic              errFlag, errPin, passDone;

  logic [DATA_W-1:0] mem [NWORDS];
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk; // 125 MHz

  assign memRdData = mem[memAddr];

  crc_scrub_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .memAddr(memAddr),
    .memRdData(memRdData), .refCrc(refCrc), .clrErr(clrErr),
    .errFlag(errFlag), .errPin(errPin), .passDone(passDone)
  );

  // expected code of the whole region, from the R4 definition
  function automatic logic [31:0] regionCrc();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < NWORDS; w++) begin
      for (int b = DATA_W - 1; b >= 0; b--) begin
        logic top = c[31] ^ mem[w][b];
        c = c << 1;
        if (top) c ^= 32'h04C1_1DB7;
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // step to the negedge where passDone is seen; returns the cycle count
  task automatic waitPass(output int cyc);
    cyc = 0;
    for (int i = 0; i < 4 * NWORDS; i++) begin
      @(negedge clk);
      cyc++;
      if (passDone) return;
    end
    cyc = -1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(memAddr == 0, "R1 addr", 32'(memAddr), 0);
    chk(!errFlag && !errPin && !passDone, "R1 outputs", {errFlag, errPin, passDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(memAddr == 0 && !passDone, "R1 idle after release", 32'(memAddr), 0);
  endtask

  task automatic t_walk();
    bit ok = 1;
    refCrc = regionCrc();
    scanEn = 1'b1;
    for (int k = 1; k < NWORDS; k++) begin
      @(negedge clk);
      if (memAddr != ADDR_W'(k) || passDone) ok = 0;
    end
    chk(ok, "R2 ascending walk", 32'(memAddr), NWORDS - 1);
    @(negedge clk);
    chk(memAddr == 0, "R2 wrap to zero", 32'(memAddr), 0);
    chk(passDone, "R8 pulse at wrap", 32'(passDone), 1);
    chk(!errFlag, "R4 matching pass", 32'(errFlag), 0);
    @(negedge clk);
    chk(!passDone && memAddr == 1, "R8 single cycle", {passDone, 28'(memAddr)}, 1);
  endtask

  task automatic t_repeatMatch();
    int cyc;
    waitPass(cyc);
    chk(cyc == NWORDS - 1, "R8 first period", cyc, NWORDS - 1);
    for (int p = 0; p < 2; p++) begin
      waitPass(cyc);
      chk(cyc == NWORDS, "R8 pass period", cyc, NWORDS);
      chk(!errFlag && !errPin, "R9 reseeded pass matches", {errFlag, errPin}, 0);
    end
  endtask

  task automatic t_badRef();
    int cyc;
    refCrc = regionCrc() ^ 32'h0000_0100;
    @(negedge clk);
    chk(!errFlag, "R5 no error mid pass", 32'(errFlag), 0);
    waitPass(cyc);
    chk(errFlag, "R5 set with passDone", 32'(errFlag), 1);
    chk(!errPin, "R7 pin lags", 32'(errPin), 0);
    @(negedge clk);
    chk(errPin, "R7 pin follows", 32'(errPin), 1);
    refCrc = regionCrc();
    waitPass(cyc);
    chk(errFlag && errPin, "R6 sticky over matching pass", {errFlag, errPin}, 3);
    clrErr = 1'b1;
    @(negedge clk);
    clrErr = 1'b0;
    chk(!errFlag, "R6 cleared", 32'(errFlag), 0);
    @(negedge clk);
    chk(!errPin, "R7 pin clears", 32'(errPin), 0);
  endtask

  task automatic t_bitFlip();
    int cyc;
    logic [31:0] goodRef = regionCrc();
    waitPass(cyc);
    mem[9] = mem[9] ^ 32'h0004_0000;
    waitPass(cyc);
    chk(errFlag, "R4 single bit flip detected", 32'(errFlag), 1);
    chk(goodRef != regionCrc(), "R4 model differs", regionCrc(), goodRef);
    mem[9] = mem[9] ^ 32'h0004_0000;
    clrErr = 1'b1;
    @(negedge clk);
    clrErr = 1'b0;
    waitPass(cyc);
    chk(!errFlag, "R4 restored region matches", 32'(errFlag), 0);
  endtask

  task automatic t_pause();
    int cyc;
    bit ok = 1;
    logic [ADDR_W-1:0] held;
    for (int i = 0; i < 5; i++) @(negedge clk);
    held = memAddr;
    scanEn = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (memAddr != held || passDone) ok = 0;
    end
    chk(ok, "R3 hold while disabled", 32'(memAddr), 32'(held));
    scanEn = 1'b1;
    waitPass(cyc);
    chk(cyc == NWORDS - int'(held), "R3 resume period", cyc, NWORDS - int'(held));
    chk(!errFlag, "R3 paused pass matches", 32'(errFlag), 0);
  endtask

  task automatic t_setBeatsClear();
    int cyc;
    waitPass(cyc);
    refCrc = ~regionCrc();
    for (int i = 0; i < NWORDS - 1; i++) @(negedge clk);
    chk(memAddr == NWORDS - 1, "R6 reached last word", 32'(memAddr), NWORDS - 1);
    clrErr = 1'b1;
    @(negedge clk);
    clrErr = 1'b0;
    chk(passDone && errFlag, "R6 set wins over clear", {passDone, errFlag}, 3);
    refCrc = regionCrc();
    clrErr = 1'b1;
    @(negedge clk);
    clrErr = 1'b0;
    chk(!errFlag, "R6 clear afterwards", 32'(errFlag), 0);
  endtask

  initial begin
    for (int w = 0; w < NWORDS; w++) mem[w] = 32'h1357_9BDF * (w + 3) ^ (w << 20);
    t_reset();
    t_walk();
    t_repeatMatch();
    t_badRef();
    t_bitFlip();
    t_pause();
    t_setBeatsClear();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule